// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block is a synthesizable behavioural model of a small serial EEPROM. It holds 128 words of 16 bits and is reached through three inputs, a chip select, a serial clock and a serial data input, plus one serial data output with an output enable that stands in for the high-impedance state. All three inputs are sampled on the system clock. A serial clock edge is a sample of 0 followed by a sample of 1.

A transaction starts when chip select goes high. The block then waits for a start bit, shifts in a two-bit opcode and an eight-bit address field, and then takes in write data or streams read data out. Programming commands start when chip select falls. A cycle counter models the internal programming time. While it runs, the next raised chip select shows busy or ready on the data output. A register array stands in for the storage cells, and an erased cell reads as all ones.

Top module: `serial_eeprom3w`

## Requirements
- R1: After reset every word reads 16'hFFFF, programming is locked, and dout_en is 0.
- R2: While chip select is high and no command is active, 0 bits are ignored; the first 1 sampled is the start bit.
- R3: After the start bit come 2 opcode bits and an 8-bit field, MSB first. Opcode 10 is read, 01 is write, 11 is erase and 00 is extended. For non-extended opcodes field bits [6:0] are the word address and bit 7 is ignored. For opcode 00, field bits [7:6] pick 11 unlock, 00 lock, 01 write-all or 10 chip erase, and bits [5:0] are ignored.
- R4: On a read, the rising clock edge that takes the last field bit makes dout_en 1 with dout 0 (a dummy bit). Each later rising edge puts out the next data bit, D15 first.
- R5: A read that keeps clocking goes on to the next word after D0, and word 127 is followed by word 0.
- R6: A write takes 16 data bits, MSB first, and on the fall of chip select replaces the addressed word completely.
- R7: Write-all takes 16 data bits and on the fall of chip select places them in every word.
- R8: Erase sets the addressed word to 16'hFFFF, and chip erase sets every word to 16'hFFFF.
- R9: While programming is locked (after reset or after a lock command), write, erase, write-all and chip erase change no word and start no programming cycle. An unlock command releases the lock.
- R10: Programming lasts PROG_CYCLES clock cycles. When chip select is raised after a programming command, dout_en is 1 and dout is 0 while busy and 1 once ready. The status display ends when a start bit is accepted.
- R11: While busy, start bits are not accepted, so a command sent during that time has no effect.
- R12: dout_en is 0 one clock after chip select is sampled low. If chip select falls before a write's 16 data bits are complete, nothing is programmed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all pins are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select, high for a transaction |
| sk | input | 1 | Serial clock; bits are taken on its rising edge |
| di | input | 1 | Serial data in: start bit, opcode, field, data |
| dout | output | 1 | Serial data out: read stream or ready (1) / busy (0) |
| dout_en | output | 1 | Output enable; 0 means the output is high-impedance |

## Verification
Every serial result is registered on the clock edge that first samples a rising sk. The bench holds sk high for two clocks and reads dout and dout_en at the following falling clock edge, so each bit is checked one edge after it is due. For the busy window the bench counts falling edges from the one where chip select is lowered. Busy must show on the second edge and still show on edge PROG_CYCLES+1, and ready must show on edge PROG_CYCLES+2. This is because the start pulse and the timer load each add one register stage. The high-impedance requirement is checked one clock after chip select drops.

// File: rtl/se3_pkg.sv
package se3_pkg;

    typedef enum logic [1:0] {
        OPC_EXT   = 2'b00,
        OPC_WRITE = 2'b01,
        OPC_READ  = 2'b10,
        OPC_ERASE = 2'b11
    } opc_e;

    typedef enum logic [1:0] {
        EXT_LOCK   = 2'b00,
        EXT_FILL   = 2'b01,
        EXT_WIPE   = 2'b10,
        EXT_UNLOCK = 2'b11
    } ext_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HUNT,
        ST_OPC,
        ST_FIELD,
        ST_DIN,
        ST_READ,
        ST_DONE
    } seq_state_e;

    // one programming request handed from the sequencer to the store
    typedef struct packed {
        logic valid;
        logic all_words;
    } prog_req_t;

    function automatic logic rise_of(input logic prev, input logic cur);
        return cur & ~prev;
    endfunction

    function automatic logic fall_of(input logic prev, input logic cur);
        return prev & ~cur;
    endfunction

endpackage

// File: rtl/se3_pins.sv
module se3_pins
    import se3_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cs,
    input  logic sk,
    output logic sk_rise,
    output logic cs_fall
);
    logic sk_q;
    logic cs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sk_q <= 1'b0;
            cs_q <= 1'b0;
        end else begin
            sk_q <= sk;
            cs_q <= cs;
        end
    end

    assign sk_rise = rise_of(sk_q, sk);
    assign cs_fall = fall_of(cs_q, cs);
endmodule

// File: rtl/se3_prog_timer.sv
module se3_prog_timer #(
    parameter int PROG_CYCLES = 2000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);
    localparam int TW = $clog2(PROG_CYCLES + 1);
    localparam logic [TW-1:0] LOAD = TW'(PROG_CYCLES);

    logic [TW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
        end else if (start) begin
            left_q <= LOAD;
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign busy = (left_q != '0);
endmodule

// File: rtl/se3_store.sv
module se3_store
    import se3_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  prog_req_t         prog_req,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic [DATA_W-1:0] prog_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int WORDS = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [WORDS];

    always_ff @(posedge clk) begin
        for (int i = 0; i < WORDS; i++) begin
            if (rst) begin
                cells[i] <= '1;
            end else if (prog_req.valid &&
                         (prog_req.all_words || prog_addr == ADDR_W'(i))) begin
                cells[i] <= prog_data;
            end
        end
    end

    assign rd_data = cells[rd_addr];
endmodule

// File: rtl/se3_seq.sv
module se3_seq
    import se3_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs,
    input  logic              cs_fall,
    input  logic              sk_rise,
    input  logic              di,
    input  logic              busy,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output prog_req_t         prog_req,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [DATA_W-1:0] prog_data,
    output logic              wen,
    output logic              dout,
    output logic              dout_en
);
    localparam int FIELD_W = ADDR_W + 1;
    localparam int CNT_W   = $clog2(DATA_W) + 1;
    localparam logic [CNT_W-1:0] OPC_LAST   = CNT_W'(1);
    localparam logic [CNT_W-1:0] FIELD_LAST = CNT_W'(FIELD_W - 1);
    localparam logic [CNT_W-1:0] DATA_LAST  = CNT_W'(DATA_W - 1);

    seq_state_e        st_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [1:0]        opc_q;
    logic [ADDR_W-1:0] field_q;
    logic [FIELD_W-1:0] field_nx;
    logic [ADDR_W-1:0] ptr_q;
    logic [ADDR_W-1:0] pend_addr_q;
    logic [DATA_W-1:0] pend_data_q;
    logic [DATA_W-1:0] shout_q;
    logic              bit_q;
    logic              wen_q;
    logic              stat_q;
    prog_req_t         pend_q;
    prog_req_t         go_q;
    opc_e              opc;
    ext_e              ext;

    assign field_nx = {field_q, di};
    assign opc      = opc_e'(opc_q);
    assign ext      = ext_e'(field_nx[FIELD_W-1 -: 2]);
    assign rd_addr  = (st_q == ST_FIELD) ? field_nx[ADDR_W-1:0] : ptr_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= ST_IDLE;
            cnt_q       <= '0;
            opc_q       <= '0;
            field_q     <= '0;
            ptr_q       <= '0;
            pend_addr_q <= '0;
            pend_data_q <= '0;
            shout_q     <= '0;
            bit_q       <= 1'b0;
            wen_q       <= 1'b0;
            stat_q      <= 1'b0;
            pend_q      <= '0;
            go_q        <= '0;
        end else if (!cs) begin
            st_q   <= ST_IDLE;
            pend_q <= '0;
            go_q   <= (cs_fall && pend_q.valid) ? pend_q : '0;
            if (cs_fall && pend_q.valid) begin
                stat_q <= 1'b1;
            end
        end else begin
            go_q <= '0;
            if (st_q == ST_IDLE) begin
                st_q <= ST_HUNT;
            end else if (sk_rise) begin
                case (st_q)
                    ST_HUNT: begin
                        if (di && !busy) begin
                            st_q   <= ST_OPC;
                            cnt_q  <= '0;
                            stat_q <= 1'b0;
                        end
                    end
                    ST_OPC: begin
                        opc_q <= {opc_q[0], di};
                        if (cnt_q == OPC_LAST) begin
                            st_q  <= ST_FIELD;
                            cnt_q <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    ST_FIELD: begin
                        field_q <= field_nx[ADDR_W-1:0];
                        cnt_q   <= cnt_q + 1'b1;
                        if (cnt_q == FIELD_LAST) begin
                            cnt_q       <= '0;
                            st_q        <= ST_DONE;
                            pend_addr_q <= field_nx[ADDR_W-1:0];
                            case (opc)
                                OPC_READ: begin
                                    shout_q <= rd_data;
                                    ptr_q   <= field_nx[ADDR_W-1:0];
                                    bit_q   <= 1'b0;
                                    st_q    <= ST_READ;
                                end
                                OPC_WRITE: begin
                                    if (wen_q) begin
                                        pend_q.all_words <= 1'b0;
                                        st_q             <= ST_DIN;
                                    end
                                end
                                OPC_ERASE: begin
                                    if (wen_q) begin
                                        pend_q      <= '{valid: 1'b1, all_words: 1'b0};
                                        pend_data_q <= '1;
                                    end
                                end
                                OPC_EXT: begin
                                    case (ext)
                                        EXT_UNLOCK: wen_q <= 1'b1;
                                        EXT_LOCK:   wen_q <= 1'b0;
                                        EXT_FILL: begin
                                            if (wen_q) begin
                                                pend_q.all_words <= 1'b1;
                                                st_q             <= ST_DIN;
                                            end
                                        end
                                        EXT_WIPE: begin
                                            if (wen_q) begin
                                                pend_q      <= '{valid: 1'b1, all_words: 1'b1};
                                                pend_data_q <= '1;
                                            end
                                        end
                                    endcase
                                end
                            endcase
                        end
                    end
                    ST_DIN: begin
                        pend_data_q <= {pend_data_q[DATA_W-2:0], di};
                        if (cnt_q == DATA_LAST) begin
                            pend_q.valid <= 1'b1;
                            st_q         <= ST_DONE;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    ST_READ: begin
                        bit_q <= shout_q[DATA_W-1];
                        if (cnt_q == DATA_LAST) begin
                            shout_q <= rd_data;
                            ptr_q   <= ptr_q + 1'b1;
                            cnt_q   <= '0;
                        end else begin
                            shout_q <= {shout_q[DATA_W-2:0], 1'b0};
                            cnt_q   <= cnt_q + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign prog_req  = go_q;
    assign prog_addr = pend_addr_q;
    assign prog_data = pend_data_q;
    assign wen       = wen_q;
    assign dout_en   = (st_q == ST_READ) || (st_q == ST_HUNT && stat_q);
    assign dout      = (st_q == ST_READ) ? bit_q : ~busy;
endmodule

// File: rtl/serial_eeprom3w.sv
module serial_eeprom3w
    import se3_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 16,
    parameter int PROG_CYCLES = 2000
) (
    input  logic clk,
    input  logic rst,
    input  logic cs,
    input  logic sk,
    input  logic di,
    output logic dout,
    output logic dout_en
);
    logic              sk_rise;
    logic              cs_fall;
    logic              busy;
    logic              wen;
    logic              prog_go;
    prog_req_t         prog_req;
    logic [ADDR_W-1:0] prog_addr;
    logic [DATA_W-1:0] prog_data;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;

    se3_pins u_pins (
        .clk     (clk),
        .rst     (rst),
        .cs      (cs),
        .sk      (sk),
        .sk_rise (sk_rise),
        .cs_fall (cs_fall)
    );

    se3_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .cs        (cs),
        .cs_fall   (cs_fall),
        .sk_rise   (sk_rise),
        .di        (di),
        .busy      (busy),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .prog_req  (prog_req),
        .prog_addr (prog_addr),
        .prog_data (prog_data),
        .wen       (wen),
        .dout      (dout),
        .dout_en   (dout_en)
    );

    assign prog_go = prog_req.valid;

    se3_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .start (prog_go),
        .busy  (busy)
    );

    se3_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .prog_req  (prog_req),
        .prog_addr (prog_addr),
        .prog_data (prog_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data)
    );
endmodule

// File: rtl/se3_checker.sv
module se3_checker (
    input logic clk,
    input logic rst,
    input logic cs,
    input logic dout,
    input logic dout_en,
    input logic busy,
    input logic wen,
    input logic prog_go
);
    // R12: output released one clock after chip select is low
    assert_hiz_R12: assert property (@(posedge clk) disable iff (rst)
        !$past(cs) |-> !dout_en);

    // R9: a programming cycle only starts while unlocked
    assert_locked_R9: assert property (@(posedge clk) disable iff (rst)
        prog_go |-> wen);

    // R9: the lock only changes inside a selected transaction
    assert_lock_change_R9: assert property (@(posedge clk) disable iff (rst)
        (wen != $past(wen)) |-> $past(cs));

    // R11: no new programming cycle while one is running
    assert_no_overlap_R11: assert property (@(posedge clk) disable iff (rst)
        prog_go |-> !busy);

    // R10: busy only follows a programming start
    assert_busy_origin_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(prog_go));

    // R10: a driven output during busy shows 0
    assert_busy_low_R10: assert property (@(posedge clk) disable iff (rst)
        (dout_en && busy) |-> !dout);
endmodule

bind serial_eeprom3w se3_checker u_se3_checker (
    .clk     (clk),
    .rst     (rst),
    .cs      (cs),
    .dout    (dout),
    .dout_en (dout_en),
    .busy    (busy),
    .wen     (wen),
    .prog_go (prog_go)
);

// File: tb/tb_serial_eeprom3w.sv
module tb_serial_eeprom3w;
    localparam int PROG = 100;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs  = 1'b0;
    logic sk  = 1'b0;
    logic di  = 1'b0;
    logic dout;
    logic dout_en;

    int total = 0;
    int bad   = 0;
    logic locked = 1'b1;

    always #5 clk = ~clk;

    serial_eeprom3w #(.ADDR_W(7), .DATA_W(16), .PROG_CYCLES(PROG)) dut (
        .clk     (clk),
        .rst     (rst),
        .cs      (cs),
        .sk      (sk),
        .di      (di),
        .dout    (dout),
        .dout_en (dout_en)
    );

    // table: {kind[1:0], addr[6:0], data[15:0]}
    localparam logic [1:0] K_WR = 2'd0, K_RD = 2'd1, K_ER = 2'd2, K_LK = 2'd3;
    localparam int NV = 16;
    localparam logic [24:0] VEC [NV] = '{
        {K_LK, 7'd0,   16'h0001},
        {K_WR, 7'd3,   16'hA5C3},
        {K_RD, 7'd3,   16'hA5C3},
        {K_WR, 7'd4,   16'h1234},
        {K_RD, 7'd4,   16'h1234},
        {K_RD, 7'd3,   16'hA5C3},
        {K_WR, 7'd3,   16'h0F0F},
        {K_RD, 7'd3,   16'h0F0F},
        {K_ER, 7'd3,   16'h0000},
        {K_RD, 7'd3,   16'hFFFF},
        {K_WR, 7'd127, 16'h8001},
        {K_RD, 7'd127, 16'h8001},
        {K_LK, 7'd0,   16'h0000},
        {K_WR, 7'd4,   16'h5555},
        {K_RD, 7'd4,   16'h1234},
        {K_LK, 7'd0,   16'h0001}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic clk_bit(input logic b, output logic o, output logic e);
        @(negedge clk);
        di = b;
        sk = 1'b0;
        @(negedge clk);
        @(negedge clk);
        sk = 1'b1;
        @(negedge clk);
        @(negedge clk);
        o = dout;
        e = dout_en;
    endtask

    task automatic send(input logic [31:0] v, input int n);
        logic o, e;
        for (int i = n - 1; i >= 0; i--) clk_bit(v[i], o, e);
    endtask

    task automatic cs_up();
        @(negedge clk);
        sk = 1'b0; di = 1'b0; cs = 1'b1;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic cs_down();
        @(negedge clk);
        sk = 1'b0; di = 1'b0; cs = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic head(input logic [1:0] op, input logic [7:0] fld, output logic o, output logic e);
        logic [10:0] f;
        f = {1'b1, op, fld};
        for (int i = 10; i >= 0; i--) clk_bit(f[i], o, e);
    endtask

    task automatic wait_ready(input logic expect_prog, input string tag);
        int n;
        cs_up();
        if (!expect_prog) begin
            chk({tag, " no status"}, {63'd0, dout_en}, 64'd0);
        end else begin
            n = 0;
            while (!(dout_en === 1'b1 && dout === 1'b1) && n < 2000) begin
                @(negedge clk);
                n++;
            end
            chk({tag, " ready"}, {63'd0, (n < 2000)}, 64'd1);
        end
        cs_down();
    endtask

    task automatic do_write(input logic [6:0] a, input logic [15:0] d);
        logic o, e;
        cs_up();
        head(2'b01, {1'b0, a}, o, e);
        send({16'd0, d}, 16);
        cs_down();
        wait_ready(!locked, "R9/R6 write");
    endtask

    task automatic do_erase(input logic [6:0] a);
        logic o, e;
        cs_up();
        head(2'b11, {1'b1, a}, o, e);
        cs_down();
        wait_ready(!locked, "R8 erase");
    endtask

    task automatic do_lock(input logic unlock);
        logic o, e;
        cs_up();
        head(2'b00, unlock ? 8'hC5 : 8'h3A, o, e);
        cs_down();
        locked = !unlock;
    endtask

    task automatic read_words(input logic [6:0] a, input int n, output logic [47:0] d);
        logic o, e;
        d = '0;
        cs_up();
        head(2'b10, {1'b0, a}, o, e);
        chk("R4 dummy bit", {62'd0, e, o}, 64'd2);
        for (int i = 0; i < n * 16; i++) begin
            clk_bit(1'b0, o, e);
            d = {d[46:0], o};
        end
        cs_down();
    endtask

    task automatic read_one(input logic [6:0] a, input logic [15:0] exp, input string tag);
        logic [47:0] d;
        read_words(a, 1, d);
        chk(tag, {48'd0, d[15:0]}, {48'd0, exp});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R10 watchdog act=%0d exp=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic o, e;
        logic [47:0] w;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        chk("R1 dout_en after reset", {63'd0, dout_en}, 64'd0);
        read_one(7'd5, 16'hFFFF, "R1 blank word");
        do_write(7'd5, 16'h1111);   // R9: locked after reset
        read_one(7'd5, 16'hFFFF, "R9 locked write ignored");

        // table walk: R3 R6 R8 R9
        for (int i = 0; i < NV; i++) begin
            case (VEC[i][24:23])
                K_WR: do_write(VEC[i][22:16], VEC[i][15:0]);
                K_RD: read_one(VEC[i][22:16], VEC[i][15:0], "R3/R6 table read");
                K_ER: do_erase(VEC[i][22:16]);
                default: do_lock(VEC[i][0]);
            endcase
        end

        // R2: leading zeros before the start bit
        cs_up();
        send(32'd0, 3);
        chk("R2 idle before start", {63'd0, dout_en}, 64'd0);
        head(2'b10, 8'h84, o, e);   // R3: field bit 7 ignored
        chk("R4 dummy after zeros", {62'd0, e, o}, 64'd2);
        for (int i = 0; i < 16; i++) begin
            clk_bit(1'b0, o, e);
            w = {w[46:0], o};
        end
        chk("R2 read after zeros", {48'd0, w[15:0]}, 64'h1234);
        cs_down();

        // R5: stream wraps 127 -> 0
        do_write(7'd126, 16'h7E7E);
        do_write(7'd0, 16'h00AA);
        read_words(7'd126, 3, w);
        chk("R5 stream 126,127,0", {16'd0, w}, {16'd0, 16'h7E7E, 16'h8001, 16'h00AA});

        // R10: exact busy window
        cs_up();
        head(2'b01, 8'h0A, o, e);
        send(32'h0000BEEF, 16);
        @(negedge clk);
        sk = 1'b0; di = 1'b0; cs = 1'b0;
        @(negedge clk);
        cs = 1'b1;
        @(negedge clk);
        chk("R10 busy shown", {62'd0, dout_en, dout}, 64'd2);
        repeat (PROG - 1) @(negedge clk);
        chk("R10 still busy at end", {62'd0, dout_en, dout}, 64'd2);
        @(negedge clk);
        chk("R10 ready", {62'd0, dout_en, dout}, 64'd3);
        cs_down();
        read_one(7'd10, 16'hBEEF, "R10 word programmed");

        // R11: erase sent while busy is ignored
        cs_up();
        head(2'b01, 8'h0B, o, e);
        send(32'h0000C0DE, 16);
        cs_down();
        cs_up();
        head(2'b11, 8'h0B, o, e);
        chk("R11 status kept during busy", {62'd0, e, o}, 64'd2);
        cs_down();
        wait_ready(1'b1, "R11");
        read_one(7'd11, 16'hC0DE, "R11 erase during busy ignored");

        // R12: abort mid-data, and output released
        cs_up();
        head(2'b01, 8'h0C, o, e);
        send(32'h000000FF, 8);
        cs_down();
        chk("R12 released when deselected", {63'd0, dout_en}, 64'd0);
        wait_ready(1'b0, "R12 aborted write");
        read_one(7'd12, 16'hFFFF, "R12 aborted write no change");

        // R7: write-all
        cs_up();
        head(2'b00, 8'h55, o, e);
        send(32'h00006C6C, 16);
        cs_down();
        wait_ready(1'b1, "R7");
        read_one(7'd9, 16'h6C6C, "R7 fill word 9");
        read_one(7'd77, 16'h6C6C, "R7 fill word 77");

        // R9: locked chip erase ignored, then R8 chip erase
        do_lock(1'b0);
        cs_up();
        head(2'b00, 8'h80, o, e);
        cs_down();
        wait_ready(1'b0, "R9 locked wipe");
        read_one(7'd9, 16'h6C6C, "R9 locked wipe ignored");
        do_lock(1'b1);
        cs_up();
        head(2'b00, 8'hBF, o, e);
        cs_down();
        wait_ready(1'b1, "R8 wipe");
        read_one(7'd9, 16'hFFFF, "R8 wipe word 9");
        read_one(7'd127, 16'hFFFF, "R8 wipe word 127");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule